// File: doc/BRIEF.md
# One-Shot Frame Refresh Sequencer

This block updates a display that keeps its own graphics memory. Software sets a single start bit once its frame buffer is ready. From then on the hardware runs the whole update without any processor or DMA transfer. It enables the upstream pixel source, waits for a start-of-frame marker and accepts exactly one frame. It cuts the pixels into display memory-write packets. After the final pixel it turns the source off, places the link in its low-power stop state, clears the busy bit and raises a one-cycle done interrupt.

Each packet carries at most `max_pix` pixels. A packet also closes early at the end of a line or at the end of the frame. Payload pixels leave the block one cycle after they are accepted. Each beat is tagged with the packet's command opcode, a first-beat flag and a last-beat flag. The packet length in pixels is valid on the last beat. A downstream framer that buffers the packet can then build the header, the CRC and the physical transfer, which this block does not cover.

Top module: `frame_refresh_seq`

## Requirements
- R1: After reset, `busy`, `src_en`, `done_irq` and `out_valid` are 0 and `link_stop` is 1.
- R2: A `start_req` pulse while `busy` is 0 makes `busy` and `src_en` 1 and `link_stop` 0 on the next clock edge.
- R3: A `start_req` while `busy` is 1 has no effect. The frame in progress runs on unchanged, and no second frame follows once it completes.
- R4: Pixels are ignored while the block is idle. Pixels that arrive before the start-of-frame marker during the wait are also ignored. Ignored pixels produce no payload beat.
- R5: Every beat of the first packet of a frame carries opcode 0x2C. Every beat of each later packet in the same frame carries 0x3C.
- R6: A packet closes (`out_last` = 1) once it holds `max_pix` pixels. A `max_pix` of 0 behaves as 1.
- R7: A packet also closes on a pixel marked end-of-line or end-of-frame. `out_len` on the last beat gives the number of pixels in that packet.
- R8: One edge after the end-of-frame pixel is accepted, `src_en` and `busy` are 0, `link_stop` is 1 and `done_irq` is 1. `done_irq` is 1 for that single cycle only.
- R9: Each accepted pixel appears on `out_data` with `out_valid` one cycle later, unchanged and in arrival order. `out_first` marks the first beat of each packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Software write of 1 to the start bit |
| max_pix | input | LEN_W | Largest number of pixels per packet (0 behaves as 1) |
| busy | output | 1 | Start bit readback; 1 until the refresh completes |
| src_en | output | 1 | Enable for the upstream pixel source |
| link_stop | output | 1 | Request for the link's low-power stop state |
| done_irq | output | 1 | One-cycle completion interrupt |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | PIX_W | Pixel value |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| pix_eof | input | 1 | Last pixel of the frame |
| out_valid | output | 1 | Payload beat valid |
| out_data | output | PIX_W | Payload pixel |
| out_first | output | 1 | First beat of a packet |
| out_last | output | 1 | Last beat of a packet |
| out_op | output | 8 | Command opcode of the packet |
| out_len | output | LEN_W | Pixel count of the packet, valid on the last beat |

## Verification
The assertions assume that `max_pix` stays constant while a refresh is in progress, because the packet-length bound is checked against its current value. They also assume that the source marks its final pixel with end-of-frame, so that every busy period ends. The bench changes `max_pix` only while the block is idle, and it closes every frame it drives with an end-of-frame pixel. It deliberately sends stray pixels while the block is idle and before the start-of-frame marker, and a second start pulse in the middle of a frame. None of these break the input assumptions.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam logic [7:0] OP_MEM_START = 8'h2C;
  localparam logic [7:0] OP_MEM_CONT  = 8'h3C;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_SOF, ST_STREAM} fr_state_t;

  // Effective per-packet limit: zero is treated as one.
  function automatic logic [7:0] eff_limit8(input logic [7:0] lim);
    return (lim == 8'd0) ? 8'd1 : lim;
  endfunction
endpackage

// File: rtl/fr_ctrl.sv
module fr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_take,
  input  logic sof_take,
  input  logic frame_end,
  output logic busy,
  output logic src_en,
  output logic link_stop,
  output logic done_irq,
  output logic waiting,
  output logic streaming
);
  import fr_pkg::*;
  fr_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      case (state)
        ST_IDLE:     if (start_take) state <= ST_WAIT_SOF;
        ST_WAIT_SOF: if (frame_end) begin
                       state <= ST_IDLE;
                       done_irq <= 1'b1;
                     end else if (sof_take) state <= ST_STREAM;
        ST_STREAM:   if (frame_end) begin
                       state <= ST_IDLE;
                       done_irq <= 1'b1;
                     end
        default:     state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign src_en    = busy;
  assign link_stop = !busy;
  assign waiting   = (state == ST_WAIT_SOF);
  assign streaming = (state == ST_STREAM);
endmodule

// File: rtl/fr_packer.sv
module fr_packer #(
  parameter int PIX_W = 24,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             accept,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_eol,
  input  logic             pix_eof,
  input  logic [LEN_W-1:0] max_pix,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_first,
  output logic             out_last,
  output logic [7:0]       out_op,
  output logic [LEN_W-1:0] out_len
);
  import fr_pkg::*;

  function automatic logic [LEN_W-1:0] eff_lim(input logic [LEN_W-1:0] lim);
    return (lim == '0) ? LEN_W'(1) : lim;
  endfunction

  function automatic logic pkt_closes(input logic [LEN_W-1:0] cnt_next,
                                      input logic [LEN_W-1:0] lim,
                                      input logic eol, input logic eof);
    return eol || eof || (cnt_next >= eff_lim(lim));
  endfunction

  logic [LEN_W-1:0] cnt;
  logic             frame_first;
  logic [LEN_W-1:0] cnt_next;
  logic             close_now;

  assign cnt_next  = cnt + LEN_W'(1);
  assign close_now = pkt_closes(cnt_next, max_pix, pix_eol, pix_eof);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      frame_first <= 1'b1;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_first   <= 1'b0;
      out_last    <= 1'b0;
      out_op      <= OP_MEM_START;
      out_len     <= '0;
    end else begin
      out_valid <= accept;
      if (frame_start) begin
        cnt         <= '0;
        frame_first <= 1'b1;
      end else if (accept) begin
        out_data  <= pix_data;
        out_first <= (cnt == '0);
        out_last  <= close_now;
        out_op    <= frame_first ? OP_MEM_START : OP_MEM_CONT;
        out_len   <= cnt_next;
        if (close_now) begin
          cnt         <= '0;
          frame_first <= 1'b0;
        end else begin
          cnt <= cnt_next;
        end
      end
    end
  end
endmodule

// File: rtl/frame_refresh_seq.sv
module frame_refresh_seq #(
  parameter int PIX_W = 24,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [LEN_W-1:0] max_pix,
  output logic             busy,
  output logic             src_en,
  output logic             link_stop,
  output logic             done_irq,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_sof,
  input  logic             pix_eol,
  input  logic             pix_eof,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_first,
  output logic             out_last,
  output logic [7:0]       out_op,
  output logic [LEN_W-1:0] out_len
);
  logic waiting, streaming;
  logic start_take, sof_take, accept, frame_end;

  assign start_take = start_req && !busy;
  assign sof_take   = pix_valid && pix_sof && waiting;
  assign accept     = sof_take || (pix_valid && streaming);
  assign frame_end  = accept && pix_eof;

  fr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_take(start_take), .sof_take(sof_take),
    .frame_end(frame_end), .busy(busy), .src_en(src_en), .link_stop(link_stop),
    .done_irq(done_irq), .waiting(waiting), .streaming(streaming)
  );

  fr_packer #(.PIX_W(PIX_W), .LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .frame_start(start_take), .accept(accept),
    .pix_data(pix_data), .pix_eol(pix_eol), .pix_eof(pix_eof), .max_pix(max_pix),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .out_op(out_op), .out_len(out_len)
  );
endmodule

// File: rtl/frame_refresh_seq_chk.sv
module frame_refresh_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             start_take,
  input logic             accept,
  input logic             pix_eol,
  input logic             pix_eof,
  input logic [LEN_W-1:0] max_pix,
  input logic             busy,
  input logic             src_en,
  input logic             link_stop,
  input logic             done_irq,
  input logic             out_valid,
  input logic             out_first,
  input logic             out_last,
  input logic [7:0]       out_op,
  input logic [LEN_W-1:0] out_len
);
  logic [LEN_W-1:0] lim;
  assign lim = (max_pix == '0) ? LEN_W'(1) : max_pix;

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> busy && src_en && !link_stop);                           // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_req && !(accept && pix_eof) |=> busy);                    // R3
  AST_NO_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));                                             // R4
  AST_OPCODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_op == 8'h2C || out_op == 8'h3C));                    // R5
  AST_OPCODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_first |-> $stable(out_op));                           // R5
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> (out_len != '0) && (out_len <= lim));         // R6
  AST_LINE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (pix_eol || pix_eof) |=> out_valid && out_last);              // R7
  AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy && !src_en && link_stop);                            // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);                                                // R8
  AST_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);                                                  // R9
endmodule

bind frame_refresh_seq frame_refresh_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_take(start_take),
  .accept(accept), .pix_eol(pix_eol), .pix_eof(pix_eof), .max_pix(max_pix),
  .busy(busy), .src_en(src_en), .link_stop(link_stop), .done_irq(done_irq),
  .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
  .out_op(out_op), .out_len(out_len)
);

// File: tb/frame_refresh_seq_test.sv
`timescale 1ns/1ps
module frame_refresh_seq_test;
  localparam int PIX_W = 24;
  localparam int LEN_W = 8;

  typedef struct packed {
    logic [PIX_W-1:0] data;
    logic             first;
    logic             last;
    logic [7:0]       op;
    logic [LEN_W-1:0] len;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [LEN_W-1:0] max_pix = 8'd4;
  logic busy, src_en, link_stop, done_irq;
  logic pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic pix_sof = 1'b0, pix_eol = 1'b0, pix_eof = 1'b0;
  logic out_valid, out_first, out_last;
  logic [PIX_W-1:0] out_data;
  logic [7:0] out_op;
  logic [LEN_W-1:0] out_len;

  int tests = 0;
  int fails = 0;
  int done_seen = 0;
  beat_t expq[$];
  logic [PIX_W-1:0] seed = 24'h100000;

  always #2.5 clk = ~clk;

  frame_refresh_seq #(.PIX_W(PIX_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .max_pix(max_pix),
    .busy(busy), .src_en(src_en), .link_stop(link_stop), .done_irq(done_irq),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof),
    .pix_eol(pix_eol), .pix_eof(pix_eof), .out_valid(out_valid),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .out_op(out_op), .out_len(out_len)
  );

  task automatic check(input string req, input logic ok, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each payload beat (R9, R5, R6, R7, R4)
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_irq) done_seen++;
      if (out_valid) begin
        if (expq.size() == 0) begin
          check("R4", 1'b0, "unexpected beat data", out_data, 0);
        end else begin
          beat_t e;
          e = expq.pop_front();
          check("R9", out_data == e.data, "data", out_data, e.data);
          check("R9", out_first == e.first, "first flag", out_first, e.first);
          check("R5", out_op == e.op, "opcode", out_op, e.op);
          check("R6/R7", out_last == e.last, "last flag", out_last, e.last);
          if (e.last) check("R7", out_len == e.len, "length", out_len, e.len);
        end
      end
    end
  end

  task automatic idle_pixels(input int n);
    for (int i = 0; i < n; i++) begin
      pix_valid = 1'b1; pix_sof = 1'b1; pix_eol = 1'b1; pix_eof = (i == n-1);
      pix_data = 24'hDEAD00 + PIX_W'(i);
      @(negedge clk);
    end
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
  endtask

  // Driver: starts a refresh, streams one frame, pushes the expected beats.
  task automatic run_frame(input int lines, input int per_line,
                           input logic [LEN_W-1:0] lim, input int junk,
                           input bit restart_mid);
    int eff, k, sent, total;
    bit ffirst;
    max_pix = lim;
    eff = (lim == 0) ? 1 : int'(lim);
    k = 0; ffirst = 1'b1; sent = 0; total = lines * per_line;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    check("R2", busy && src_en && !link_stop, "busy/src_en/link_stop after start",
          {busy, src_en, link_stop}, 3'b110);
    for (int j = 0; j < junk; j++) begin   // R4: no start-of-frame yet
      pix_valid = 1'b1; pix_data = 24'hBAD000 + PIX_W'(j);
      @(negedge clk);
    end
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < per_line; p++) begin
        beat_t e;
        bit eol, eof;
        eol = (p == per_line-1);
        eof = eol && (l == lines-1);
        seed = seed + 24'h000013;
        k++;
        e.data = seed; e.first = (k == 1); e.op = ffirst ? 8'h2C : 8'h3C;
        e.last = eol || eof || (k == eff); e.len = LEN_W'(k);
        expq.push_back(e);
        if (e.last) begin k = 0; ffirst = 1'b0; end
        pix_valid = 1'b1; pix_data = seed; pix_sof = (sent == 0);
        pix_eol = eol; pix_eof = eof;
        start_req = restart_mid && (sent == total/2);   // R3
        sent++;
        @(negedge clk);
        start_req = 1'b0;
        if (!eof && (sent % 3 == 0)) begin   // idle gap
          pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
          @(negedge clk);
        end
      end
    end
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
    check("R8", !busy && !src_en && link_stop && done_irq, "end state",
          {busy, src_en, link_stop, done_irq}, 4'b0011);
    @(negedge clk);
    check("R8", !done_irq, "done pulse width", done_irq, 0);
    check("R3", !busy, "no second frame", busy, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1", !busy && !src_en && link_stop && !done_irq && !out_valid,
              "reset outputs", {busy, src_en, link_stop, done_irq, out_valid}, 5'b00100);
        rst_n = 1'b1;
        @(negedge clk);
        idle_pixels(3);                    // R4: idle pixels ignored
        repeat (2) @(negedge clk);
        check("R4", expq.size() == 0 && !busy, "idle pixels start nothing", busy, 0);
        run_frame(2, 5, 8'd2, 0, 1'b0);    // R6 limit 2 + R7 truncation
        repeat (2) @(negedge clk);
        run_frame(3, 4, 8'd4, 2, 1'b0);    // R6 coincides with line end
        repeat (2) @(negedge clk);
        run_frame(1, 7, 8'd0, 0, 1'b0);    // R6 zero behaves as one
        repeat (2) @(negedge clk);
        run_frame(2, 6, 8'd16, 3, 1'b1);   // R7 line truncation, R3 restart
        idle_pixels(4);                    // R3: nothing queued after done
        repeat (3) @(negedge clk);
        check("R3", !busy && !src_en, "still idle after stray start", busy, 0);
        check("R9", expq.size() == 0, "all expected beats seen", expq.size(), 0);
        check("R8", done_seen == 4, "done interrupt count", done_seen, 4);
      end
      begin
        repeat (20000) @(negedge clk);
        check("WDOG", 1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule